// File: doc/BRIEF.md
# Integer Load/Store Execute Unit

This unit carries out one fixed-point memory operation at a time for a 64-bit register-based processor. A decoded operation arrives on a valid/ready port and brings three register indices (target, base, index), a 16-bit signed immediate, flags for indexed form, update form and store, an access size, a signedness bit and a requested byte order. The unit reads its operands through three combinational register-file read ports. It forms the effective address and checks the operation for illegal encodings. It then issues a single request on a valid/ready data-memory port. For loads it waits for the response, reorders and extends the data, and returns register writebacks.

Back-pressure works as follows. `op_ready` is high only while the unit is idle, and an operation is taken on a cycle where `op_valid` and `op_ready` are both high. `mem_req_valid` stays high, with all request fields unchanged, until `mem_req_ready` is sampled high. At most one request is outstanding. A load then waits for `mem_rsp_valid`, and a response arriving at any other time is ignored. Writebacks and the illegal flag are single-cycle pulses with no back-pressure.

Data on both memory buses is lane-ordered: the byte at the lowest address of the access sits in bits [7:0], and the access occupies the low 1, 2, 4 or 8 bytes.

Top module: `lsu_exec`

## Requirements
- R1: The effective address is base plus displacement. The base is zero when the base index is 0 and is the base register's contents otherwise. Register 0 is never read as a base.
- R2: In immediate form (`op_xform`=0) the displacement is the 16-bit immediate sign-extended to 64 bits. In indexed form (`op_xform`=1) it is the contents of the index register.
- R3: When `cfg_narrow` is 1, bits [63:32] of the effective address are cleared. This applies both to the memory request and to the address written back in update forms.
- R4: An update-form operation (`op_update`=1) is illegal when the base index is 0. An update-form load is also illegal when the base index equals the target index. In either case `illegal` pulses high for one cycle, in the cycle after acceptance, and no memory request or writeback is produced.
- R5: With `cfg_wide`=0, two load kinds are illegal: a signed word load, and any doubleword load (`op_size`=3).
- R6: Two load encodings are always illegal: a signed byte load, and a signed word load in immediate form with update.
- R7: `op_size` encodes byte=0, halfword=1, word=2, doubleword=3. A load result is the low 1/2/4/8 bytes of the reordered response. It is zero-extended, or sign-extended when `op_sgn`=1.
- R8: The effective byte order is little-endian when `op_le` XOR `cfg_ctx_le` is 1 and big-endian otherwise. Big-endian reverses the low N bytes of the access on both load data and store data.
- R9: A store sends the low N bytes of the target register (reordered per R8) with the upper bytes zero, and sets `mem_req_store`=1. It produces no target writeback. With update, the base register receives the effective address in the cycle after the request handshake.
- R10: `mem_req_valid` rises in the cycle after acceptance and holds, with stable fields, until `mem_req_ready`. After a load's handshake no new request appears before the response. `busy`=1 and `op_ready`=0 from acceptance until the operation completes.
- R11: A load's writebacks appear in the cycle after `mem_rsp_valid`. An update-form load presents the target and base writebacks in the same cycle, on separate ports, to different registers.
- R12: After reset the unit is idle: `op_ready`=1, and `busy`, `mem_req_valid`, `illegal` and both writeback valids are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation valid |
| op_ready | output | 1 | Unit idle, operation accepted this cycle |
| op_rt | input | 5 | Target (load) / source (store) register index |
| op_ra | input | 5 | Base register index |
| op_rb | input | 5 | Index register index |
| op_imm | input | 16 | Signed immediate displacement |
| op_xform | input | 1 | 1 = indexed displacement |
| op_update | input | 1 | 1 = write address back to base |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code |
| op_sgn | input | 1 | Sign-extend load result |
| op_le | input | 1 | Requested little-endian order |
| cfg_narrow | input | 1 | 32-bit address mode |
| cfg_wide | input | 1 | 64-bit load kinds permitted |
| cfg_ctx_le | input | 1 | Context default byte-order flip |
| rf_ra_idx | output | 5 | Read index, base |
| rf_ra_data | input | 64 | Read data, base |
| rf_rb_idx | output | 5 | Read index, index register |
| rf_rb_data | input | 64 | Read data, index register |
| rf_rt_idx | output | 5 | Read index, store source |
| rf_rt_data | input | 64 | Read data, store source |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | Effective address |
| mem_req_store | output | 1 | Request is a store |
| mem_req_size | output | 2 | Access size code |
| mem_req_wdata | output | 64 | Lane-ordered store data |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_data | input | 64 | Lane-ordered load data |
| wb_t_valid | output | 1 | Target writeback valid |
| wb_t_idx | output | 5 | Target writeback index |
| wb_t_data | output | 64 | Target writeback data |
| wb_u_valid | output | 1 | Base (update) writeback valid |
| wb_u_idx | output | 5 | Base writeback index |
| wb_u_data | output | 64 | Base writeback data |
| illegal | output | 1 | Illegal-operation pulse |
| busy | output | 1 | Operation in flight |

## Verification
The bench builds the unit with its default parameters: 64-bit data, 32 registers, a 16-bit immediate and a 32-bit narrow address. That brings within reach the sign boundary of the immediate (0x8000), the truncation of a negative base in narrow mode, and all four access sizes under both byte orders. Memory back-pressure and response delays of several cycles are applied, so that request hold and busy timing are exercised.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  parameter int XLEN     = 64;
  parameter int NREG     = 32;
  parameter int IMM_W    = 16;
  parameter int NARROW_W = 32;
  localparam int RIDX_W  = $clog2(NREG);
  localparam int NBYTES  = XLEN / 8;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
(
  input  logic [RIDX_W-1:0] rt,
  input  logic [RIDX_W-1:0] ra,
  input  logic [IMM_W-1:0]  imm,
  input  logic              xform,
  input  logic              update,
  input  logic              store,
  input  size_e             size,
  input  logic              sgn,
  input  logic              narrow,
  input  logic              wide,
  input  logic [XLEN-1:0]   ra_data,
  input  logic [XLEN-1:0]   rb_data,
  output logic [XLEN-1:0]   ea,
  output logic              bad
);
  logic [XLEN-1:0] base, disp, sum;
  logic upd_bad, wide_bad, hole_bad;

  always_comb begin
    base = (ra == '0) ? '0 : ra_data;
    disp = xform ? rb_data : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    sum  = base + disp;
    ea   = narrow ? {{(XLEN-NARROW_W){1'b0}}, sum[NARROW_W-1:0]} : sum;
  end

  always_comb begin
    upd_bad  = update && ((ra == '0) || (!store && ra == rt));
    wide_bad = !store && !wide && ((size == SZ_D) || (size == SZ_W && sgn));
    hole_bad = !store && sgn &&
               ((size == SZ_B) || (size == SZ_W && update && !xform));
    bad      = upd_bad || wide_bad || hole_bad;
  end
endmodule

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
(
  input  size_e           size,
  input  logic            big,
  input  logic            sgn,
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);
  int n;
  logic [XLEN-1:0] ordered, keep;
  logic top_bit;

  always_comb begin
    n = 1 << int'(size);
    ordered = '0;
    keep    = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < n) begin
        keep[8*i +: 8] = 8'hFF;
        if (big) ordered[8*i +: 8] = din[8*(n-1-i) +: 8];
        else     ordered[8*i +: 8] = din[8*i +: 8];
      end
    end
    top_bit = ordered[8*n-1];
    dout = (sgn && top_bit) ? (ordered | ~keep) : ordered;
  end
endmodule

// File: rtl/lsu_exec.sv
module lsu_exec
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [RIDX_W-1:0] op_rt,
  input  logic [RIDX_W-1:0] op_ra,
  input  logic [RIDX_W-1:0] op_rb,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic              op_xform,
  input  logic              op_update,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic              op_sgn,
  input  logic              op_le,
  input  logic              cfg_narrow,
  input  logic              cfg_wide,
  input  logic              cfg_ctx_le,
  output logic [RIDX_W-1:0] rf_ra_idx,
  input  logic [XLEN-1:0]   rf_ra_data,
  output logic [RIDX_W-1:0] rf_rb_idx,
  input  logic [XLEN-1:0]   rf_rb_data,
  output logic [RIDX_W-1:0] rf_rt_idx,
  input  logic [XLEN-1:0]   rf_rt_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic              mem_req_store,
  output logic [1:0]        mem_req_size,
  output logic [XLEN-1:0]   mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wb_t_valid,
  output logic [RIDX_W-1:0] wb_t_idx,
  output logic [XLEN-1:0]   wb_t_data,
  output logic              wb_u_valid,
  output logic [RIDX_W-1:0] wb_u_idx,
  output logic [XLEN-1:0]   wb_u_data,
  output logic              illegal,
  output logic              busy
);
  state_e            state;
  logic [XLEN-1:0]   ag_ea, st_lane, ld_lane;
  logic              ag_bad, in_big;
  logic [RIDX_W-1:0] q_rt, q_ra;
  logic              q_update, q_big, q_sgn;
  size_e             q_size;

  assign rf_ra_idx = op_ra;
  assign rf_rb_idx = op_rb;
  assign rf_rt_idx = op_rt;
  assign in_big    = !(op_le ^ cfg_ctx_le);

  lsu_agen u_agen (
    .rt(op_rt), .ra(op_ra), .imm(op_imm), .xform(op_xform),
    .update(op_update), .store(op_store), .size(size_e'(op_size)),
    .sgn(op_sgn), .narrow(cfg_narrow), .wide(cfg_wide),
    .ra_data(rf_ra_data), .rb_data(rf_rb_data),
    .ea(ag_ea), .bad(ag_bad)
  );

  lsu_lane u_st_lane (
    .size(size_e'(op_size)), .big(in_big), .sgn(1'b0),
    .din(rf_rt_data), .dout(st_lane)
  );

  lsu_lane u_ld_lane (
    .size(q_size), .big(q_big), .sgn(q_sgn),
    .din(mem_rsp_data), .dout(ld_lane)
  );

  assign op_ready      = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_size  = q_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      illegal       <= 1'b0;
      wb_t_valid    <= 1'b0;
      wb_t_idx      <= '0;
      wb_t_data     <= '0;
      wb_u_valid    <= 1'b0;
      wb_u_idx      <= '0;
      wb_u_data     <= '0;
      mem_req_addr  <= '0;
      mem_req_store <= 1'b0;
      mem_req_wdata <= '0;
      q_rt          <= '0;
      q_ra          <= '0;
      q_update      <= 1'b0;
      q_big         <= 1'b0;
      q_sgn         <= 1'b0;
      q_size        <= SZ_B;
    end else begin
      illegal    <= 1'b0;
      wb_t_valid <= 1'b0;
      wb_u_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (op_valid) begin
            if (ag_bad) begin
              illegal <= 1'b1;
            end else begin
              mem_req_addr  <= ag_ea;
              mem_req_store <= op_store;
              mem_req_wdata <= op_store ? st_lane : '0;
              q_rt          <= op_rt;
              q_ra          <= op_ra;
              q_update      <= op_update;
              q_big         <= in_big;
              q_sgn         <= op_sgn;
              q_size        <= size_e'(op_size);
              state         <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            if (mem_req_store) begin
              wb_u_valid <= q_update;
              wb_u_idx   <= q_ra;
              wb_u_data  <= mem_req_addr;
              state      <= ST_IDLE;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            wb_t_valid <= 1'b1;
            wb_t_idx   <= q_rt;
            wb_t_data  <= ld_lane;
            wb_u_valid <= q_update;
            wb_u_idx   <= q_ra;
            wb_u_data  <= mem_req_addr;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) &&
      $stable(mem_req_store) && $stable(mem_req_size));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && !mem_req_store |=> !mem_req_valid && busy);

  assert_illegal_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req_valid && !wb_t_valid && !wb_u_valid);

  assert_dual_wb_distinct_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_t_valid && wb_u_valid |-> wb_t_idx != wb_u_idx);

  assert_wb_after_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_t_valid |-> $past(mem_rsp_valid));

  assert_upd_base_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_u_valid |-> wb_u_idx != '0);

  assert_narrow_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready && cfg_narrow && !ag_bad |=>
      mem_req_addr[XLEN-1:NARROW_W] == '0);
endmodule

// File: tb/tb_lsu_exec.sv
module tb_lsu_exec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic op_valid = 0, op_ready;
  logic [4:0] op_rt = 0, op_ra = 0, op_rb = 0;
  logic [15:0] op_imm = 0;
  logic op_xform = 0, op_update = 0, op_store = 0, op_sgn = 0, op_le = 0;
  logic [1:0] op_size = 0;
  logic cfg_narrow = 0, cfg_wide = 1, cfg_ctx_le = 0;
  logic [4:0] rf_ra_idx, rf_rb_idx, rf_rt_idx;
  logic [63:0] rf_ra_data, rf_rb_data, rf_rt_data;
  logic mem_req_valid, mem_req_ready = 0, mem_req_store;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic [1:0] mem_req_size;
  logic mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = 0;
  logic wb_t_valid, wb_u_valid, illegal, busy;
  logic [4:0] wb_t_idx, wb_u_idx;
  logic [63:0] wb_t_data, wb_u_data;

  logic [63:0] regs [32];
  assign rf_ra_data = regs[rf_ra_idx];
  assign rf_rb_data = regs[rf_rb_idx];
  assign rf_rt_data = regs[rf_rt_idx];

  int checks = 0, errors = 0;
  bit done = 0;

  lsu_exec dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] m_ea(input int ra, input int rb, input logic [15:0] imm,
                                       input bit xf);
    logic [63:0] b, d, s;
    b = (ra == 0) ? 64'd0 : regs[ra];
    d = xf ? regs[rb] : 64'($signed(imm));
    s = b + d;
    if (cfg_narrow) s = s & 64'h0000_0000_FFFF_FFFF;
    return s;
  endfunction

  function automatic bit m_bad(input int rt, input int ra, input bit xf, input bit upd,
                               input bit st, input int sz, input bit sg);
    if (upd && (ra == 0 || (!st && ra == rt))) return 1;
    if (!st && !cfg_wide && (sz == 3 || (sz == 2 && sg))) return 1;
    if (!st && sg && (sz == 0 || (sz == 2 && upd && !xf))) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] m_order(input logic [63:0] v, input int sz, input bit big,
                                          input bit sg);
    int n;
    logic [63:0] r;
    n = 1 << sz;
    r = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] byt;
      byt = v[8*i +: 8];
      r[8*(big ? (n-1-i) : i) +: 8] = byt;
    end
    if (sg && n < 8 && r[8*n-1]) r = r | ~((64'd1 << (8*n)) - 64'd1);
    return r;
  endfunction

  task automatic do_op(input string req, input int rt, input int ra, input int rb,
                       input logic [15:0] imm, input bit xf, input bit upd, input bit st,
                       input int sz, input bit sg, input bit le,
                       input int rdy_dly, input int rsp_dly, input logic [63:0] raw);
    logic [63:0] e_ea, e_wd, e_ld;
    bit bad, big;
    @(negedge clk);
    bad  = m_bad(rt, ra, xf, upd, st, sz, sg);
    big  = !(le ^ cfg_ctx_le);
    e_ea = m_ea(ra, rb, imm, xf);
    e_wd = st ? m_order(regs[rt], sz, big, 0) : 64'd0;
    e_ld = m_order(raw, sz, big, sg);
    chk(op_ready == 1, "R10", "ready before op", 64'(op_ready), 1);
    op_valid = 1; op_rt = 5'(rt); op_ra = 5'(ra); op_rb = 5'(rb); op_imm = imm;
    op_xform = xf; op_update = upd; op_store = st; op_size = 2'(sz); op_sgn = sg; op_le = le;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0;
    if (bad) begin
      chk(illegal == 1 && mem_req_valid == 0 && !wb_t_valid && !wb_u_valid && !busy,
          req, "illegal pulse/quiet", {illegal, mem_req_valid, wb_t_valid, wb_u_valid, busy}, 64'h10);
      @(posedge clk); @(negedge clk);
      chk(illegal == 0 && mem_req_valid == 0 && !wb_u_valid, req, "illegal one cycle",
          64'(illegal), 0);
      return;
    end
    chk(illegal == 0, req, "legal no flag", 64'(illegal), 0);
    chk(mem_req_valid == 1 && busy == 1 && op_ready == 0, "R10", "request issued",
        {mem_req_valid, busy, op_ready}, 64'b110);
    chk(mem_req_addr == e_ea, req, "address", mem_req_addr, e_ea);
    chk(mem_req_store == st && mem_req_size == 2'(sz), req, "kind/size",
        {mem_req_store, mem_req_size}, {st, 2'(sz)});
    if (st) chk(mem_req_wdata == e_wd, req, "store data", mem_req_wdata, e_wd);
    for (int k = 0; k < rdy_dly; k++) begin
      @(posedge clk); @(negedge clk);
      chk(mem_req_valid == 1 && mem_req_addr == e_ea, "R10", "hold under backpressure",
          mem_req_addr, e_ea);
    end
    mem_req_ready = 1;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 0;
    if (st) begin
      chk(wb_t_valid == 0 && busy == 0, "R9", "store done no rt wb", 64'(wb_t_valid), 0);
      chk(wb_u_valid == upd, "R9", "store update valid", 64'(wb_u_valid), 64'(upd));
      if (upd) chk(wb_u_idx == 5'(ra) && wb_u_data == e_ea, "R9", "store update data",
                   wb_u_data, e_ea);
      return;
    end
    chk(mem_req_valid == 0 && busy == 1, "R10", "waiting, no new request",
        {mem_req_valid, busy}, 64'b01);
    for (int k = 0; k < rsp_dly; k++) begin
      @(posedge clk); @(negedge clk);
      chk(!wb_t_valid && !wb_u_valid && busy && !mem_req_valid, "R10", "wait quiet",
          64'(wb_t_valid), 0);
    end
    mem_rsp_valid = 1; mem_rsp_data = raw;
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = 64'hBAD0_BAD0_BAD0_BAD0;
    chk(wb_t_valid == 1 && wb_t_idx == 5'(rt), "R11", "rt writeback", 64'(wb_t_idx), 64'(rt));
    chk(wb_t_data == e_ld, req, "load data", wb_t_data, e_ld);
    chk(wb_u_valid == upd, "R11", "same-cycle update wb", 64'(wb_u_valid), 64'(upd));
    if (upd) chk(wb_u_idx == 5'(ra) && wb_u_data == e_ea, "R11", "update wb data",
                 wb_u_data, e_ea);
    chk(busy == 0, "R10", "idle after load", 64'(busy), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h0101_0101_0101_0101 * 64'(i + 1);
    regs[0] = 64'hDEAD_BEEF_0000_0000;
    regs[3] = 64'h0000_0000_0000_1000;
    regs[4] = 64'hFFFF_FFFF_FFFF_FFF0;
    regs[5] = 64'h1122_3344_5566_7788;
    regs[9] = 64'hFFFF_FFFF_8000_0010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(op_ready && !busy && !mem_req_valid && !illegal && !wb_t_valid && !wb_u_valid,
        "R12", "in reset", {op_ready, busy, mem_req_valid}, 64'b100);
    rst_n = 1;
    @(negedge clk);
    chk(op_ready && !busy && !mem_req_valid && !illegal && !wb_t_valid && !wb_u_valid,
        "R12", "after reset", {op_ready, busy, mem_req_valid}, 64'b100);

    // R1 R7 R8: byte load, immediate, big-endian
    do_op("R1", 10, 3, 0, 16'h0010, 0, 0, 0, 0, 0, 0, 0, 0, 64'h0000_0000_0000_00AB);
    // R1 R2: base index 0 gives zero base; negative immediate
    do_op("R2", 11, 0, 0, 16'h8000, 0, 0, 0, 1, 0, 0, 1, 1, 64'h0000_0000_0000_34F2);
    // R7 R8: signed halfword, indexed, little-endian
    do_op("R7", 12, 3, 4, 16'h0, 1, 0, 0, 1, 1, 1, 0, 2, 64'h0000_0000_0000_9A01);
    // R10: back-pressure and delayed response, big-endian word
    do_op("R8", 13, 3, 0, 16'h0004, 0, 0, 0, 2, 0, 0, 2, 3, 64'h0000_0000_8877_6655);
    // R11: signed word, update indexed, dual writeback
    do_op("R11", 8, 6, 5, 16'h0, 1, 1, 0, 2, 1, 1, 1, 0, 64'h0000_0000_F000_0001);
    // R7: doubleword little-endian
    do_op("R7", 14, 3, 0, 16'h7FF8, 0, 0, 0, 3, 0, 1, 0, 0, 64'h0123_4567_89AB_CDEF);
    // R8: op_le xor ctx_le = 0 -> big-endian doubleword
    cfg_ctx_le = 1;
    do_op("R8", 15, 3, 0, 16'h0, 0, 0, 0, 3, 0, 1, 0, 1, 64'h0123_4567_89AB_CDEF);
    do_op("R8", 15, 3, 0, 16'h0, 0, 0, 0, 1, 0, 0, 0, 0, 64'h0000_0000_0000_1122);
    cfg_ctx_le = 0;
    // R5: wide-only loads
    cfg_wide = 0;
    do_op("R5", 16, 3, 0, 16'h0, 0, 0, 0, 3, 0, 0, 0, 0, 64'h0);
    do_op("R5", 16, 3, 5, 16'h0, 1, 0, 0, 2, 1, 0, 0, 0, 64'h0);
    do_op("R5", 16, 3, 0, 16'h0, 0, 0, 0, 2, 0, 0, 0, 0, 64'h0000_0000_8000_0000);
    cfg_wide = 1;
    // R4: illegal update forms
    do_op("R4", 17, 0, 0, 16'h0, 0, 1, 0, 2, 0, 0, 0, 0, 64'h0);
    do_op("R4", 7, 7, 0, 16'h0, 0, 1, 0, 0, 0, 0, 0, 0, 64'h0);
    do_op("R4", 7, 0, 0, 16'h0, 0, 1, 1, 0, 0, 0, 0, 0, 64'h0);
    // R9: store with ra == rt is legal, update writes base
    do_op("R9", 7, 7, 0, 16'h0020, 0, 1, 1, 1, 0, 1, 1, 0, 64'h0);
    // R6: encoding holes
    do_op("R6", 18, 3, 0, 16'h0, 0, 0, 0, 0, 1, 0, 0, 0, 64'h0);
    do_op("R6", 18, 3, 0, 16'h0, 0, 1, 0, 2, 1, 0, 0, 0, 64'h0);
    // R3: narrow mode truncation, load with update
    cfg_narrow = 1;
    do_op("R3", 19, 4, 0, 16'h0008, 0, 1, 0, 2, 0, 0, 0, 0, 64'h0000_0000_DEAD_BEEF);
    do_op("R3", 19, 9, 3, 16'h0, 1, 1, 1, 3, 0, 0, 2, 0, 64'h0);
    cfg_narrow = 0;
    // R9: big-endian doubleword store, little-endian halfword store
    do_op("R9", 5, 3, 0, 16'hFFF8, 0, 0, 1, 3, 0, 0, 0, 0, 64'h0);
    do_op("R9", 5, 3, 4, 16'h0, 1, 0, 1, 1, 1, 1, 3, 0, 64'h0);

    done = 1;
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule